// File: doc/BRIEF.md
# In-band Xon/Xoff Flow Control Engine

This block handles character-based flow control for a single serial channel. It has two sides that run independently. On the receive side it watches every completed character. It compares each one with four programmed control characters: two halt codes and two resume codes. A halt match raises `tx_halt` and a resume match drops it. Depending on the option field, a single character counts as a match, or the two codes of a kind must arrive on consecutive receive strobes. Every halt match also sets `xoff_irq`, which stays set until the interrupt identification register is read. Matched characters are not removed from the data stream. The surrounding channel still writes them into its receive FIFO.

On the transmit side the block watches the receive FIFO fill level. When the level climbs to the halt level, it asks the transmitter to send a halt code (or a pair of them). When the level falls to the resume level, it asks for a resume code. The transmitter must give these requests priority over its normal FIFO data. It must sample `tx_halt` only at a character boundary, so the character already on the line always finishes.

Top module: `swfc_engine`

## Requirements
- R1: After reset `tx_halt`, `xoff_irq` and `ins_valid` are all 0.
- R2: `flow_opt[1:0]` sets the receive mode. 01 compares with `xoff_a`/`xon_a` and 10 compares with `xoff_b`/`xon_b`. In these modes a single strobed halt-code match sets `tx_halt` in the cycle after the strobe, and a resume-code match clears it. If one character matches both a halt code and a resume code, the halt wins.
- R3: Receive mode 11 needs a pair on consecutive `rx_valid` strobes: `xoff_a` then `xoff_b` halts, and `xon_a` then `xon_b` resumes. Any other character between the two codes discards the partial match.
- R4: Every halt match sets `xoff_irq` in the next cycle. An `iir_rd` pulse clears it in the next cycle. If a halt match and `iir_rd` occur in the same cycle, the flag ends up set.
- R5: Receive mode 00 compares nothing. It clears `tx_halt` and any partial pair match. It leaves `xoff_irq` unchanged.
- R6: Transmit mode `flow_opt[3:2]` nonzero, not throttled, and `rx_level >= halt_lvl`: in the next cycle a halt request appears on `ins_valid`. It is made once and is not repeated while the level stays high.
- R7: Throttled and `rx_level <= resume_lvl`: in the next cycle a resume request appears, once.
- R8: Transmit mode 01 sends `xoff_a`/`xon_a`, and mode 10 sends `xoff_b`/`xon_b`. Mode 11 sends `xoff_a` then `xoff_b` (or `xon_a` then `xon_b`) as two separate handshakes. The level is not evaluated between the two characters of a pair.
- R9: `ins_char` holds steady while `ins_valid` is 1 and `ins_ready` is 0. A request ends in the cycle after its last `ins_valid && ins_ready` handshake.
- R10: A request with no character accepted yet is withdrawn, with no new request, when the opposite level condition appears first. So halt and resume codes always alternate on the line.
- R11: Transmit mode 00 drops any request, clears the throttled state and raises no requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is complete (no back-pressure) |
| rx_char | input | 8 | Received character, valid with `rx_valid` |
| rx_level | input | LVL_W | Receive FIFO fill count |
| halt_lvl | input | LVL_W | Fill count at which a halt code is requested |
| resume_lvl | input | LVL_W | Fill count at which a resume code is requested |
| flow_opt | input | 4 | [3:2] transmit mode, [1:0] receive mode |
| xoff_a | input | 8 | First halt code |
| xoff_b | input | 8 | Second halt code |
| xon_a | input | 8 | First resume code |
| xon_b | input | 8 | Second resume code |
| iir_rd | input | 1 | Pulse: interrupt identification register read |
| tx_halt | output | 1 | Transmitter must stop at the next character boundary |
| ins_valid | output | 1 | Control character insertion request |
| ins_ready | input | 1 | Transmitter takes `ins_char` this cycle |
| ins_char | output | 8 | Control character to insert |
| xoff_irq | output | 1 | Halt-code-received interrupt flag |

## Verification
The bench builds the engine with `LVL_W = 4`, so the fill count runs from 0 to 15. A random walk of one step per cycle therefore crosses both the halt and resume levels many times in a few thousand cycles. For each block of random cycles the bench chooses a new halt/resume pair. Some pairs are adjacent levels, where a pending request is often cancelled before the transmitter's randomly timed `ins_ready` takes it. The receive alphabet is weighted toward the four control codes, so pairs, broken pairs and halt/resume collisions occur often.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  typedef enum logic [1:0] {
    SEL_NONE   = 2'b00,
    SEL_FIRST  = 2'b01,
    SEL_SECOND = 2'b10,
    SEL_PAIR   = 2'b11
  } swfc_sel_e;

  typedef enum logic [1:0] {
    REQ_IDLE = 2'b00,
    REQ_OFF  = 2'b01,
    REQ_ON   = 2'b10
  } swfc_req_e;

  typedef struct packed {
    logic [7:0] on_b;
    logic [7:0] on_a;
    logic [7:0] off_b;
    logic [7:0] off_a;
  } swfc_chars_t;
endpackage

// File: rtl/swfc_rx_match.sv
module swfc_rx_match
  import swfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  swfc_sel_e   sel,
  input  swfc_chars_t codes,
  input  logic        rx_valid,
  input  logic [7:0]  rx_char,
  input  logic        iir_rd,
  output logic        tx_halt,
  output logic        xoff_irq
);
  localparam int unsigned NCODE = 4;

  logic [NCODE-1:0][7:0] code_vec;
  logic [NCODE-1:0]      eq;
  logic                  arm_off, arm_on;
  logic                  off_hit, on_hit;

  assign code_vec = codes;

  for (genvar gi = 0; gi < NCODE; gi++) begin : g_cmp
    assign eq[gi] = (rx_char == code_vec[gi]);
  end

  // index 0 off_a, 1 off_b, 2 on_a, 3 on_b
  always_comb begin
    off_hit = 1'b0;
    on_hit  = 1'b0;
    case (sel)
      SEL_FIRST: begin
        off_hit = rx_valid & eq[0];
        on_hit  = rx_valid & eq[2];
      end
      SEL_SECOND: begin
        off_hit = rx_valid & eq[1];
        on_hit  = rx_valid & eq[3];
      end
      SEL_PAIR: begin
        off_hit = rx_valid & arm_off & eq[1];
        on_hit  = rx_valid & arm_on  & eq[3];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_halt  <= 1'b0;
      arm_off  <= 1'b0;
      arm_on   <= 1'b0;
      xoff_irq <= 1'b0;
    end else begin
      if (sel == SEL_NONE) begin
        tx_halt <= 1'b0;
      end else if (off_hit) begin
        tx_halt <= 1'b1;
      end else if (on_hit) begin
        tx_halt <= 1'b0;
      end

      if (sel != SEL_PAIR) begin
        arm_off <= 1'b0;
        arm_on  <= 1'b0;
      end else if (rx_valid) begin
        arm_off <= eq[0] & ~(off_hit | on_hit);
        arm_on  <= eq[2] & ~(off_hit | on_hit);
      end

      if (off_hit) begin
        xoff_irq <= 1'b1;
      end else if (iir_rd) begin
        xoff_irq <= 1'b0;
      end
    end
  end

  // R2
  halt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_halt) |-> $past(rx_valid));
  // R4
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && !rx_valid) |=> !xoff_irq);
  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xoff_irq) |-> $past(rx_valid) && $rose(tx_halt) || $past(rx_valid) && $past(tx_halt));
  // R5
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |=> !tx_halt);
endmodule

// File: rtl/swfc_tx_insert.sv
module swfc_tx_insert
  import swfc_pkg::*;
#(
  parameter int unsigned LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  swfc_sel_e        sel,
  input  swfc_chars_t      codes,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] halt_lvl,
  input  logic [LVL_W-1:0] resume_lvl,
  output logic             ins_valid,
  input  logic             ins_ready,
  output logic [7:0]       ins_char
);
  swfc_req_e req;
  logic      throttled;
  logic      second;
  logic      at_halt, at_resume, use_b, take;

  assign at_halt   = (rx_level >= halt_lvl);
  assign at_resume = (rx_level <= resume_lvl);
  assign ins_valid = (req != REQ_IDLE);
  assign take      = ins_valid & ins_ready;
  assign use_b     = (sel == SEL_SECOND) | ((sel == SEL_PAIR) & second);

  always_comb begin
    if (req == REQ_ON) ins_char = use_b ? codes.on_b : codes.on_a;
    else               ins_char = use_b ? codes.off_b : codes.off_a;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || sel == SEL_NONE) begin
      req       <= REQ_IDLE;
      throttled <= 1'b0;
      second    <= 1'b0;
    end else if (take) begin
      if (sel == SEL_PAIR && !second) begin
        second <= 1'b1;
      end else begin
        req    <= REQ_IDLE;
        second <= 1'b0;
      end
    end else if (!second) begin
      case (req)
        REQ_IDLE: begin
          if (!throttled && at_halt) begin
            throttled <= 1'b1;
            req       <= REQ_OFF;
          end else if (throttled && at_resume) begin
            throttled <= 1'b0;
            req       <= REQ_ON;
          end
        end
        REQ_OFF: if (at_resume) begin
          throttled <= 1'b0;
          req       <= REQ_IDLE;
        end
        REQ_ON: if (at_halt) begin
          throttled <= 1'b1;
          req       <= REQ_IDLE;
        end
        default: req <= REQ_IDLE;
      endcase
    end
  end

  // kind of the last request whose first character went out, for checking only
  swfc_req_e last_sent;
  always_ff @(posedge clk) begin
    if (!rst_n || sel == SEL_NONE) last_sent <= REQ_IDLE;
    else if (take && !second)      last_sent <= req;
  end

  // R10
  alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !second) |-> (req != last_sent));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && $past(ins_valid && !ins_ready) && $stable(sel) && $stable(req))
      |-> $stable(ins_char));
  // R11
  tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |=> !ins_valid);
  // R6
  req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ins_valid) |-> $past(at_halt || at_resume));
endmodule

// File: rtl/swfc_engine.sv
module swfc_engine
  import swfc_pkg::*;
#(
  parameter int unsigned LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_char,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] halt_lvl,
  input  logic [LVL_W-1:0] resume_lvl,
  input  logic [3:0]       flow_opt,
  input  logic [7:0]       xoff_a,
  input  logic [7:0]       xoff_b,
  input  logic [7:0]       xon_a,
  input  logic [7:0]       xon_b,
  input  logic             iir_rd,
  output logic             tx_halt,
  output logic             ins_valid,
  input  logic             ins_ready,
  output logic [7:0]       ins_char,
  output logic             xoff_irq
);
  swfc_chars_t codes;
  swfc_sel_e   rx_sel, tx_sel;

  assign codes  = '{on_b: xon_b, on_a: xon_a, off_b: xoff_b, off_a: xoff_a};
  assign rx_sel = swfc_sel_e'(flow_opt[1:0]);
  assign tx_sel = swfc_sel_e'(flow_opt[3:2]);

  swfc_rx_match u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (rx_sel),
    .codes    (codes),
    .rx_valid (rx_valid),
    .rx_char  (rx_char),
    .iir_rd   (iir_rd),
    .tx_halt  (tx_halt),
    .xoff_irq (xoff_irq)
  );

  swfc_tx_insert #(.LVL_W(LVL_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (tx_sel),
    .codes      (codes),
    .rx_level   (rx_level),
    .halt_lvl   (halt_lvl),
    .resume_lvl (resume_lvl),
    .ins_valid  (ins_valid),
    .ins_ready  (ins_ready),
    .ins_char   (ins_char)
  );
endmodule

// File: tb/swfc_engine_test.sv
`timescale 1ns/1ps
module swfc_engine_test;
  localparam int LW = 4;
  localparam logic [7:0] OFFA = 8'h13, OFFB = 8'h93, ONA = 8'h11, ONB = 8'h91;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, rx_valid, iir_rd, ins_ready;
  logic [7:0] rx_char;
  logic [LW-1:0] rx_level, halt_lvl, resume_lvl;
  logic [3:0] flow_opt;
  logic tx_halt, ins_valid, xoff_irq;
  logic [7:0] ins_char;

  swfc_engine #(.LVL_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .rx_level(rx_level), .halt_lvl(halt_lvl), .resume_lvl(resume_lvl),
    .flow_opt(flow_opt), .xoff_a(OFFA), .xoff_b(OFFB), .xon_a(ONA), .xon_b(ONB),
    .iir_rd(iir_rd), .tx_halt(tx_halt), .ins_valid(ins_valid),
    .ins_ready(ins_ready), .ins_char(ins_char), .xoff_irq(xoff_irq)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic m_halt, m_irq, m_aoff, m_aon, m_thr;
  int   m_pend, m_idx; // pend: 0 idle, 1 halt code, 2 resume code

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_char();
    logic b;
    b = (flow_opt[3:2] == 2'd2) || (flow_opt[3:2] == 2'd3 && m_idx == 1);
    if (m_pend == 2) return b ? ONB : ONA;
    return b ? OFFB : OFFA;
  endfunction

  task automatic model_next();
    logic off, on, hs, ah, ar;
    int rm, tm;
    rm = int'(flow_opt[1:0]);
    tm = int'(flow_opt[3:2]);
    off = 0; on = 0;
    if (rx_valid && rm == 1) begin off = (rx_char == OFFA); on = (rx_char == ONA); end
    if (rx_valid && rm == 2) begin off = (rx_char == OFFB); on = (rx_char == ONB); end
    if (rx_valid && rm == 3) begin off = m_aoff && rx_char == OFFB; on = m_aon && rx_char == ONB; end
    if (off) m_irq = 1; else if (iir_rd) m_irq = 0;
    if (rm == 0) m_halt = 0; else if (off) m_halt = 1; else if (on) m_halt = 0;
    if (rm != 3) begin m_aoff = 0; m_aon = 0; end
    else if (rx_valid) begin
      m_aoff = (rx_char == OFFA) && !(off || on);
      m_aon  = (rx_char == ONA) && !(off || on);
    end
    hs = (m_pend != 0) && ins_ready;
    ah = rx_level >= halt_lvl;
    ar = rx_level <= resume_lvl;
    if (tm == 0) begin m_thr = 0; m_pend = 0; m_idx = 0; end
    else if (hs) begin
      if (tm == 3 && m_idx == 0) m_idx = 1; else begin m_pend = 0; m_idx = 0; end
    end else if (m_idx == 0) begin
      if (m_pend == 0) begin
        if (!m_thr && ah) begin m_thr = 1; m_pend = 1; end
        else if (m_thr && ar) begin m_thr = 0; m_pend = 2; end
      end else if (m_pend == 1 && ar) begin m_thr = 0; m_pend = 0; end
      else if (m_pend == 2 && ah) begin m_thr = 1; m_pend = 0; end
    end
  endtask

  task automatic step(string tag);
    model_next();
    @(posedge clk); #1;
    chk(tag, {7'd0, tx_halt}, {7'd0, m_halt});
    chk(tag, {7'd0, xoff_irq}, {7'd0, m_irq});
    chk(tag, {7'd0, ins_valid}, {7'd0, m_pend != 0});
    if (m_pend != 0) chk(tag, ins_char, exp_char());
  endtask

  task automatic rx(logic [7:0] c, string tag);
    rx_valid = 1; rx_char = c; step(tag); rx_valid = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int lvl;
    void'($urandom(32'd2024));
    rst_n = 0; rx_valid = 0; rx_char = 0; iir_rd = 0; ins_ready = 0;
    rx_level = 0; halt_lvl = 10; resume_lvl = 3; flow_opt = 4'b0000;
    m_halt = 0; m_irq = 0; m_aoff = 0; m_aon = 0; m_thr = 0; m_pend = 0; m_idx = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {5'd0, tx_halt, xoff_irq, ins_valid}, 8'd0);
    rst_n = 1;

    // R2 single compare, first codes
    flow_opt = 4'b0001;
    rx(OFFA, "R2");
    chk("R2", {7'd0, tx_halt}, 8'd1);
    chk("R4", {7'd0, xoff_irq}, 8'd1);
    rx(ONB, "R2");               // second code ignored in mode 01
    chk("R2", {7'd0, tx_halt}, 8'd1);
    rx(ONA, "R2");
    chk("R2", {7'd0, tx_halt}, 8'd0);
    flow_opt = 4'b0010;
    rx(OFFA, "R2");
    chk("R2", {7'd0, tx_halt}, 8'd0);
    rx(OFFB, "R2");
    chk("R2", {7'd0, tx_halt}, 8'd1);
    // R4 clear and set-wins
    iir_rd = 1; step("R4"); iir_rd = 0;
    chk("R4", {7'd0, xoff_irq}, 8'd0);
    iir_rd = 1; rx(OFFB, "R4"); iir_rd = 0;
    chk("R4", {7'd0, xoff_irq}, 8'd1);
    // R3 pair mode
    flow_opt = 4'b0011;
    rx(ONA, "R3"); rx(ONB, "R3");
    chk("R3", {7'd0, tx_halt}, 8'd0);
    rx(OFFA, "R3"); rx(8'h41, "R3"); rx(OFFB, "R3");
    chk("R3", {7'd0, tx_halt}, 8'd0);
    rx(OFFA, "R3"); rx(OFFB, "R3");
    chk("R3", {7'd0, tx_halt}, 8'd1);
    rx(ONA, "R3"); rx(OFFA, "R3"); rx(ONB, "R3");
    chk("R3", {7'd0, tx_halt}, 8'd1);
    // R5 receive mode off
    iir_rd = 1; step("R5"); iir_rd = 0;
    rx(OFFA, "R3");
    flow_opt = 4'b0000; step("R5");
    chk("R5", {7'd0, tx_halt}, 8'd0);
    rx(OFFB, "R5");
    chk("R5", {6'd0, tx_halt, xoff_irq}, 8'd0);

    // R6 / R9 halt request, single code
    flow_opt = 4'b0100; ins_ready = 0;
    rx_level = 10; step("R6");
    chk("R6", {7'd0, ins_valid}, 8'd1);
    chk("R8", ins_char, OFFA);
    repeat (3) step("R9");
    chk("R9", ins_char, OFFA);
    ins_ready = 1; step("R9"); ins_ready = 0;
    chk("R9", {7'd0, ins_valid}, 8'd0);
    rx_level = 15; repeat (4) step("R6");
    chk("R6", {7'd0, ins_valid}, 8'd0);
    // R7 resume
    rx_level = 3; step("R7");
    chk("R7", ins_char, ONA);
    ins_ready = 1; step("R7"); ins_ready = 0;
    // R8 pair on transmit
    flow_opt = 4'b1100; rx_level = 11; step("R8");
    chk("R8", ins_char, OFFA);
    ins_ready = 1; step("R8");
    chk("R8", ins_char, OFFB);
    step("R8"); ins_ready = 0;
    chk("R8", {7'd0, ins_valid}, 8'd0);
    // R10 cancel pending resume, then pending halt
    rx_level = 2; step("R10");
    chk("R10", ins_char, ONA);
    rx_level = 12; step("R10");
    chk("R10", {7'd0, ins_valid}, 8'd0);
    repeat (3) step("R10");
    chk("R10", {7'd0, ins_valid}, 8'd0);
    // R11 transmit mode off
    flow_opt = 4'b1000; rx_level = 1; step("R11");
    chk("R11", ins_char, ONB);
    flow_opt = 4'b0000; step("R11");
    chk("R11", {7'd0, ins_valid}, 8'd0);
    rx_level = 14; repeat (3) step("R11");
    chk("R11", {7'd0, ins_valid}, 8'd0);

    // constrained random
    lvl = 7;
    for (int blk = 0; blk < 16; blk++) begin
      int h;
      flow_opt = 4'($urandom);
      h = 1 + int'($urandom % 15);
      halt_lvl = LW'(h);
      resume_lvl = LW'(h - 1 - int'($urandom % 2 == 0 ? 0 : $urandom % h));
      for (int c = 0; c < 200; c++) begin
        int r, k;
        r = int'($urandom % 3);
        if (r == 0 && lvl < 15) lvl++;
        else if (r == 1 && lvl > 0) lvl--;
        rx_level = LW'(lvl);
        rx_valid = ($urandom % 5) < 2;
        k = int'($urandom % 6);
        rx_char = (k == 0) ? OFFA : (k == 1) ? OFFB : (k == 2) ? ONA :
                  (k == 3) ? ONB : 8'($urandom);
        ins_ready = $urandom % 2;
        iir_rd = ($urandom % 10) == 0;
        case (int'(flow_opt[1:0]))
          3: step("R3");
          0: step("R5");
          default: step("R2");
        endcase
      end
      rx_valid = 0; iir_rd = 0;
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule